// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one timer channel built around a free-running 16-bit up-counter and four general registers, numbered 0 to 3. A per-register mode input sets each general register as a capture register or as a compare register. In capture mode, a one-cycle strobe copies the counter into the register. In compare mode, the register raises an event whenever the counter equals its value. Each register has its own sticky event flag, and the counter has a wrap flag. Together these make up a byte-wide status register. An interrupt request output reports any flag whose enable bit is set.

Software uses a simple single-cycle register bus. Read data is combinational from the address. A flag cannot be set from the bus. To clear a flag, software must first read the status while that flag is 1 and then write 0 to the same bit. Each flag holds a private "armed" marker. A status read arms the marker, and the next status write consumes it.

Bus map (3-bit address): 0 = counter, 1..4 = general registers 0..3, 5 = status, 6 = interrupt enable, 7 = reads zero.

Top module: `capcmp_timer`

## Requirements
- R1: While reset is asserted and just after it, the counter, general registers, flags, enables and `irq` are all 0.
- R2: The counter adds 1 each clock. A bus write to address 0 loads the counter, and the count continues from the loaded value.
- R3: Status bit 4 is set on the clock where the counter wraps from 0xFFFF to 0x0000.
- R4: When `modeSel[i]`=1, a `capStrobe[i]` pulse copies the counter value of that cycle into general register i and sets status bit i (bit 0 = register 0 ... bit 3 = register 3).
- R5: When `modeSel[i]`=0, status bit i is set on the clock where the counter equals general register i. A bus write to the register does not set the flag by itself.
- R6: Status bits 7..5 always read 0. Writing 1 to any status bit never sets a flag.
- R7: Writing 0 to a flag clears it only if an earlier status read returned that flag as 1. Without such a read, the write has no effect.
- R8: The armed marker is used up by the next status write, even if that write left the flag set. A second write of 0 does not clear the flag.
- R9: If a set event and a valid clear hit the same flag on the same clock, the flag stays 1.
- R10: `irq` is 1 exactly when some flag is 1 and its bit in the 5-bit enable register (address 6, readable) is 1.
- R11: A capture strobe on a register in compare mode leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| capStrobe | input | 4 | Capture strobes, one per general register |
| modeSel | input | 4 | 1 = capture mode, 0 = compare mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that all inputs are known after reset and change only away from the rising edge. The bench drives every bus access, strobe and mode change on the falling edge. The assertions also assume that a status read and a status write never happen on the same clock, which the single-access bus already ensures. The bench keeps the bus idle during reset. It changes modes only while the counter is far from the compare value, so that no match fires by accident.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_GR  = 4;
  localparam int FLAG_W  = NUM_GR + 1;
  localparam int OVF_BIT = NUM_GR;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_GR0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd6;

  typedef struct packed {
    logic              cntWr;
    logic [NUM_GR-1:0] grWr;
    logic              statRd;
    logic              statWr;
    logic              ienWr;
    logic [CNT_W-1:0]  wdata;
  } strobes_t;
endpackage

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [NUM_GR-1:0] capStrobe,
  input  logic [NUM_GR-1:0] modeSel,
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] ien,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [FLAG_W-1:0] setEvt
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] grQ [NUM_GR];
  logic [NUM_GR-1:0] capEvt;
  logic [NUM_GR-1:0] cmpEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (stb.cntWr) cntQ <= stb.wdata;
    else                cntQ <= cntQ + 1'b1;
  end

  for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
    assign capEvt[i] = capStrobe[i] & modeSel[i];
    assign cmpEvt[i] = ~modeSel[i] & (cntQ == grQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            grQ[i] <= '0;
      else if (capEvt[i])   grQ[i] <= cntQ;
      else if (stb.grWr[i]) grQ[i] <= stb.wdata;
    end

    // R4: capture copies the counter value of that cycle
    a_r4_capture_value: assert property (@(posedge clk) disable iff (!rstN)
      (capStrobe[i] && modeSel[i]) |=> grQ[i] == $past(cntQ));
    // R11: without a qualified capture or a bus write the register holds
    a_r11_gr_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!(capStrobe[i] && modeSel[i]) && !stb.grWr[i]) |=> $stable(grQ[i]));
  end

  assign setEvt[NUM_GR-1:0] = capEvt | cmpEvt;
  assign setEvt[OVF_BIT]    = ~stb.cntWr & (&cntQ);

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_CNT) rdData = cntQ;
    if (rdAddr == ADDR_STAT) rdData = CNT_W'(flags);
    if (rdAddr == ADDR_IEN) rdData = CNT_W'(ien);
    for (int i = 0; i < NUM_GR; i++) begin
      if (rdAddr == ADDR_W'(ADDR_GR0 + ADDR_W'(i))) rdData = grQ[i];
    end
  end

  // R2: free-running increment and load
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntWr |=> cntQ == $past(cntQ) + 1'b1);
  a_r2_count_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntWr |=> cntQ == $past(stb.wdata));
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic [FLAG_W-1:0] setEvt,
  output strobes_t          stb,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] ien,
  output logic              irq
);
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] armedQ;
  logic [FLAG_W-1:0] ienQ;
  logic [FLAG_W-1:0] clrReq;
  logic              wrAcc;
  logic              rdAcc;

  assign wrAcc = busSel & busWr;
  assign rdAcc = busSel & ~busWr;

  always_comb begin
    stb.cntWr  = wrAcc & (busAddr == ADDR_CNT);
    stb.statRd = rdAcc & (busAddr == ADDR_STAT);
    stb.statWr = wrAcc & (busAddr == ADDR_STAT);
    stb.ienWr  = wrAcc & (busAddr == ADDR_IEN);
    stb.wdata  = busWdata;
    for (int i = 0; i < NUM_GR; i++)
      stb.grWr[i] = wrAcc & (busAddr == ADDR_W'(ADDR_GR0 + ADDR_W'(i)));
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    assign clrReq[i] = stb.statWr & armedQ[i] & ~busWdata[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i]  <= 1'b0;
        armedQ[i] <= 1'b0;
      end else begin
        flagQ[i] <= setEvt[i] | (flagQ[i] & ~clrReq[i]);
        if (stb.statWr)      armedQ[i] <= 1'b0;
        else if (stb.statRd) armedQ[i] <= armedQ[i] | flagQ[i];
      end
    end

    // R9: a set event always leaves the flag at 1
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      setEvt[i] |=> flagQ[i]);
    // R6: a flag only rises from a hardware event, never from the bus
    a_r6_rise_from_event: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(setEvt[i]));
    // R7: a flag only falls after an armed write of 0
    a_r7_fall_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagQ[i]) |-> $past(armedQ[i] && stb.statWr && !busWdata[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ienQ <= '0;
    else if (stb.ienWr) ienQ <= busWdata[FLAG_W-1:0];
  end

  assign flags = flagQ;
  assign ien   = ienQ;
  assign irq   = |(flagQ & ienQ);

  // R8: any status write consumes every marker
  a_r8_arm_consumed: assert property (@(posedge clk) disable iff (!rstN)
    stb.statWr |=> armedQ == '0);
  // R10: no request while nothing is enabled
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0) |-> !irq);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [NUM_GR-1:0] capStrobe,
  input  logic [NUM_GR-1:0] modeSel,
  output logic              irq
);
  strobes_t          stb;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] ien;
  logic [FLAG_W-1:0] setEvt;

  capcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .setEvt(setEvt),
    .stb(stb), .flags(flags), .ien(ien), .irq(irq)
  );

  capcmp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .capStrobe(capStrobe),
    .modeSel(modeSel), .flags(flags), .ien(ien), .rdAddr(busAddr),
    .rdData(busRdata), .setEvt(setEvt)
  );
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  capStrobe = '0;
  logic [3:0]  modeSel = 4'hF;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CNT = 3'd0, A_STAT = 3'd5, A_IEN = 3'd6;

  capcmp_timer u_capcmp_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .capStrobe(capStrobe), .modeSel(modeSel), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [15:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [15:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic clearFlags();
    logic [15:0] v;
    busRead(A_STAT, v);
    busWrite(A_STAT, 16'h0000);
  endtask

  task automatic pulseCap(int i);
    capStrobe[i] = 1'b1;
    @(negedge clk);
    capStrobe = '0;
  endtask

  initial begin
    logic [15:0] v, w;
    logic [15:0] kvals [4];
    kvals[0] = 16'h0010; kvals[1] = 16'h1234; kvals[2] = 16'h8000; kvals[3] = 16'hABCD;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 irq", {15'd0, irq}, 16'h0);
    busAddr = A_STAT; #1 check("R1 status", busRdata, 16'h0);
    busAddr = A_CNT;  #1 check("R1 counter", busRdata, 16'h0);
    busAddr = 3'd1;   #1 check("R1 gr0", busRdata, 16'h0);
    busAddr = A_IEN;  #1 check("R1 ien", busRdata, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: counter steps and loads
    busRead(A_CNT, v);
    busRead(A_CNT, w);
    check("R2 step", w, v + 16'd1);
    busWrite(A_CNT, 16'h4321);
    busRead(A_CNT, v);
    check("R2 load", v, 16'h4321);
    busRead(A_CNT, v);
    check("R2 after load", v, 16'h4322);

    // R3: wrap flag
    busWrite(A_CNT, 16'hFFFE);
    @(negedge clk);
    busAddr = A_STAT; #1 check("R3 before wrap", busRdata, 16'h0000);
    @(negedge clk);
    #1 check("R3 wrap", busRdata, 16'h0010);
    check("R6 reserved zero", {8'd0, busRdata[15:8]} | {13'd0, busRdata[7:5]}, 16'h0);
    clearFlags();
    busRead(A_STAT, v);
    check("R7 wrap cleared", v, 16'h0);

    busWrite(A_IEN, 16'h001F);
    // per-register sweep
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] base;
        base = kvals[k] + 16'(i * 16'h0101);
        // R4: capture
        busWrite(A_CNT, base);
        pulseCap(i);
        busRead(3'(1 + i), v);
        check("R4 capture value", v, base);
        // R7: write 0 with no prior read has no effect
        busWrite(A_STAT, 16'h0000);
        busRead(A_STAT, v);
        check("R7 unarmed write ignored", v, 16'(1 << i));
        // R8: marker consumed by a write of ones
        busWrite(A_STAT, 16'h00FF);
        busWrite(A_STAT, 16'h0000);
        busRead(A_STAT, v);
        check("R8 marker consumed", v, 16'(1 << i));
        // R7: armed write 0 clears
        busWrite(A_STAT, 16'h0000);
        busRead(A_STAT, v);
        check("R7 armed clear", v, 16'h0);
        // R5: compare
        busWrite(3'(1 + i), base + 16'd5);
        busRead(A_STAT, v);
        check("R5 gr write sets nothing", v, 16'h0);
        busWrite(A_CNT, base);
        modeSel[i] = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 before match", {15'd0, irq}, 16'h0);
        @(negedge clk);
        check("R5 match", {15'd0, irq}, 16'h1);
        modeSel[i] = 1'b1;
        busRead(A_STAT, v);
        check("R5 match bit", v, 16'(1 << i));
        busWrite(A_STAT, 16'h0000);
      end
    end

    // R11: capture strobe in compare mode ignored
    busWrite(3'd2, 16'h0F0F);
    busWrite(A_CNT, 16'h7000);
    modeSel[1] = 1'b0;
    pulseCap(1);
    busRead(3'd2, v);
    check("R11 compare-mode strobe", v, 16'h0F0F);
    modeSel[1] = 1'b1;
    busRead(A_STAT, v);
    check("R11 no flag", v, 16'h0);

    // R9: set wins over clear
    pulseCap(2);
    busRead(A_STAT, v);
    busSel = 1'b1; busWr = 1'b1; busAddr = A_STAT; busWdata = 16'h0;
    capStrobe[2] = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; capStrobe = '0;
    busRead(A_STAT, v);
    check("R9 set wins", v, 16'h0004);
    busWrite(A_STAT, 16'h0);

    // R6: writing ones never sets
    busWrite(A_STAT, 16'hFFFF);
    busRead(A_STAT, v);
    check("R6 ones ignored", v, 16'h0);

    // R10: enable sweep with flags 0 and 2 set
    pulseCap(0);
    pulseCap(2);
    for (int e = 0; e < 32; e++) begin
      busWrite(A_IEN, 16'(e));
      #1 check("R10 irq", {15'd0, irq}, {15'd0, |(5'(e) & 5'b00101)});
    end
    busRead(A_IEN, v);
    check("R10 enable readback", v, 16'h001F);
    clearFlags();
    check("R10 irq after clear", {15'd0, irq}, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule